// File: doc/BRIEF.md
# CAN Transmit/Receive FIFO Mailbox Windows

This block holds the message queues between a CPU and a CAN protocol engine. Each direction has a small ring of frame entries. An entry is a 32-bit identifier word, a 4-bit length code and eight data bytes. The CPU never addresses ring slots directly. It sees the transmit queue through one fixed mailbox window and the receive queue through another.

To send, software fills the transmit window with the identifier, the length and the data words. It then writes the step code 0xFF to the transmit pointer register, which copies the window into the ring as a new entry. The protocol engine drains entries in order through a valid/ready handshake.

Received frames arrive from the engine on a push interface. Software reads the oldest frame through the receive window. It then writes 0xFF to the receive pointer register, which drops that frame and shows the next one. Control registers give the enable bits, the number of unsent entries and the receive-empty status. Two sticky event flags, one per direction, drive a single interrupt line through an enable mask. The frame-bit engine and acceptance filtering are not part of this block.

Top module: `can_mbx_windows`

## Requirements
- R1: After a synchronous active-low reset, the following hold. Both queues are disabled and empty. TX control reads 0 and RX control reads 0x80. Interrupt status and enable read 0. `tx_valid`, `rx_ready`, `rx_overrun` and `irq` are 0.
- R2: The register address works as follows.
  - Bit 9 = 0 selects a mailbox window. Bits 8:3 give the mailbox index and bits 2:0 give the field: 0 identifier word, 1 length code, 2 data bytes 0–3, 3 data bytes 4–7. Byte k of a data word sits in bits 8k+7:8k. The other fields read 0.
  - Mailbox 56 is the transmit window. Its fields are writable and read back as written.
  - Bit 9 = 1 selects a control register by bits 2:0: 0 TX control, 1 RX control, 2 TX pointer, 3 RX pointer, 4 interrupt status, 5 interrupt enable.
- R3: A TX-pointer write with bits 7:0 = 0xFF appends the window contents to the transmit queue, but only when TX is enabled and fewer than DEPTH entries are held. Any other value, a full queue or a disabled queue leaves the queue unchanged.
- R4: `tx_valid` is high while TX is enabled and the queue is not empty. It presents the oldest entry on `tx_id`, `tx_len` and `tx_data`. A cycle with `tx_valid` and `tx_ready` both high removes that entry, so entries leave in commit order.
- R5: TX control bit 0 is the read/write enable. Bits 3:1 read the number of unsent entries, and read 0 while disabled.
- R6: `rx_ready` equals the RX enable. A cycle with `rx_valid` high, RX enabled and the queue not full stores the frame.
- R7: A push with RX enabled and the queue full drops the frame and leaves the queue unchanged. `rx_overrun` is high for exactly the following cycle.
- R8: Mailbox 60 shows the oldest received frame, and reads 0 when the queue is empty or disabled. An RX-pointer write with bits 7:0 = 0xFF removes that frame if one is held. RX control bit 0 is the read/write enable, and bit 7 reads 1 while the queue is empty or disabled.
- R9: Each of the following sets its status flag.
  - Status bit 3 sets in the cycle after each transmit handshake.
  - Status bit 4 sets in the cycle after each stored receive frame.
  - Writing the status register clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. A set in the same cycle as a clear wins.
  - `irq` is high while any flag is set together with its enable bit (the same positions in the enable register).
- R10: Writing 0 to a queue's enable bit empties that queue. After re-enabling, the queue holds nothing.
- R11: The identifier word is stored and returned with all 32 bits. Bit 31 is the extended-format flag and bit 30 is the remote-request flag. A standard ID sits at bits 28:18 and an extended ID at bits 28:0. The length code keeps only bits 3:0 of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | MBX_IDX_W+4 | Register address (region, mailbox, field) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| tx_valid | output | 1 | Transmit entry available |
| tx_ready | input | 1 | Engine takes the transmit entry |
| tx_id | output | 32 | Identifier word of the oldest transmit entry |
| tx_len | output | 4 | Length code of the oldest transmit entry |
| tx_data | output | 64 | Data bytes of the oldest transmit entry |
| rx_valid | input | 1 | Engine offers a received frame |
| rx_ready | output | 1 | Receive side accepts frames |
| rx_id | input | 32 | Received identifier word |
| rx_len | input | 4 | Received length code |
| rx_data | input | 64 | Received data bytes |
| rx_overrun | output | 1 | One-cycle pulse: frame dropped on a full queue |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a depth of 4, the transmit window at mailbox 56 and the receive window at mailbox 60. The shallow depth means a handful of commits or pushes reaches the full boundary. This exposes the ignored fifth commit, the dropped fifth frame with its overrun pulse, and pointer wrap-around when queues are refilled. The default mailbox indices let the bench check that other indices read 0. A behavioural queue model is compared every clock against the handshake outputs and the register read path. It covers simultaneous commit and drain, a flag clear that collides with a new set, and disabling a queue that still holds entries.

// File: rtl/can_mbx_pkg.sv
// Shared types and encodings for the CAN mailbox FIFO windows.
// Assumes a 32-bit register data path and 8-byte classic frames.
package can_mbx_pkg;

    localparam int ID_W   = 32;
    localparam int LEN_W  = 4;
    localparam int DATA_W = 64;

    // One queued frame
    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
    } mbx_entry_t;

    localparam int ENTRY_W = $bits(mbx_entry_t);

    // Field select inside a mailbox window
    typedef enum logic [2:0] {
        F_ID  = 3'd0,
        F_LEN = 3'd1,
        F_DLO = 3'd2,
        F_DHI = 3'd3
    } win_field_e;

    // Control register select
    typedef enum logic [2:0] {
        C_TXCTL = 3'd0,
        C_RXCTL = 3'd1,
        C_TXPTR = 3'd2,
        C_RXPTR = 3'd3,
        C_ISTAT = 3'd4,
        C_IEN   = 3'd5
    } ctl_sel_e;

    localparam logic [7:0] PTR_STEP = 8'hFF;
    localparam int IRQ_TX_BIT   = 3;
    localparam int IRQ_RX_BIT   = 4;
    localparam int RX_EMPTY_BIT = 7;

endpackage

// File: rtl/can_mbx_ring.sv
// Ring buffer of DEPTH entries with occupancy count.
// Push on full and pop on empty are ignored. While flush is high the
// pointers and count are held at zero and nothing is accepted.
module can_mbx_ring #(
    parameter  int DEPTH = 4,
    parameter  int W     = 100,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    // Advance a slot pointer with wrap at DEPTH
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push & ~full & ~flush;
    assign do_pop  = pop & ~empty & ~flush;

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Entry storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    assign head  = mem[rp];
    assign count = cnt;

endmodule

// File: rtl/can_mbx_irq.sv
// Sticky event flags: set by hardware events, cleared by writing 0.
// A set in the same cycle as a clear takes priority.
module can_mbx_irq #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic          wr_en,
    input  logic [NF-1:0] wr_keep,
    output logic [NF-1:0] flags
);

    for (genvar i = 0; i < NF; i++) begin : g_flag
        // One flag: reset, set-wins, write-0-clears
        always_ff @(posedge clk) begin
            if (!rst_n)        flags[i] <= 1'b0;
            else if (set[i])   flags[i] <= 1'b1;
            else if (wr_en)    flags[i] <= flags[i] & wr_keep[i];
        end
    end

endmodule

// File: rtl/can_mbx_windows.sv
// CAN transmit/receive FIFOs reached through fixed mailbox windows.
// The CPU stages a frame in the TX window and commits it with a 0xFF
// pointer write. It reads the RX window and releases it the same way.
// The engine side uses valid/ready. Assumes single-cycle register
// writes and a combinational read path.
module can_mbx_windows
    import can_mbx_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int MBX_IDX_W = 6,
    parameter int TX_MBX    = 56,
    parameter int RX_MBX    = 60
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [MBX_IDX_W+3:0]   reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    output logic                   tx_valid,
    input  logic                   tx_ready,
    output logic [ID_W-1:0]        tx_id,
    output logic [LEN_W-1:0]       tx_len,
    output logic [DATA_W-1:0]      tx_data,
    input  logic                   rx_valid,
    output logic                   rx_ready,
    input  logic [ID_W-1:0]        rx_id,
    input  logic [LEN_W-1:0]       rx_len,
    input  logic [DATA_W-1:0]      rx_data,
    output logic                   rx_overrun,
    output logic                   irq
);

    localparam int AW = MBX_IDX_W + 4;
    localparam int CW = $clog2(DEPTH + 1);

    // Address decode
    logic                 ctl_hit, tx_win, rx_win, ptr_step;
    logic [MBX_IDX_W-1:0] mbx_idx;
    logic [2:0]           fld;

    assign ctl_hit  = reg_addr[AW-1];
    assign mbx_idx  = reg_addr[AW-2:3];
    assign fld      = reg_addr[2:0];
    assign tx_win   = !ctl_hit && (mbx_idx == MBX_IDX_W'(TX_MBX));
    assign rx_win   = !ctl_hit && (mbx_idx == MBX_IDX_W'(RX_MBX));
    assign ptr_step = (reg_wdata[7:0] == PTR_STEP);

    // Control state
    logic       tx_en_q, rx_en_q;
    logic [1:0] ien_q;

    // Enable and interrupt-enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            rx_en_q <= 1'b0;
            ien_q   <= '0;
        end else if (reg_wr && ctl_hit) begin
            if (fld == C_TXCTL) tx_en_q <= reg_wdata[0];
            if (fld == C_RXCTL) rx_en_q <= reg_wdata[0];
            if (fld == C_IEN)   ien_q   <= {reg_wdata[IRQ_RX_BIT], reg_wdata[IRQ_TX_BIT]};
        end
    end

    // Transmit window staging
    mbx_entry_t stage_q;

    // Capture CPU writes into the TX window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (reg_wr && tx_win) begin
            case (fld)
                F_ID:    stage_q.id          <= reg_wdata;
                F_LEN:   stage_q.len         <= reg_wdata[LEN_W-1:0];
                F_DLO:   stage_q.data[31:0]  <= reg_wdata;
                F_DHI:   stage_q.data[63:32] <= reg_wdata;
                default: stage_q             <= stage_q;
            endcase
        end
    end

    // Transmit ring
    logic          tx_commit, tx_pop, tx_full, tx_empty;
    logic [CW-1:0] tx_cnt;
    mbx_entry_t    tx_head;

    assign tx_commit = reg_wr && ctl_hit && (fld == C_TXPTR) && ptr_step && tx_en_q;
    assign tx_valid  = tx_en_q && !tx_empty;
    assign tx_pop    = tx_valid && tx_ready;

    can_mbx_ring #(.DEPTH(DEPTH), .W(ENTRY_W)) u_tx_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!tx_en_q),
        .push  (tx_commit),
        .wdata (stage_q),
        .pop   (tx_pop),
        .head  (tx_head),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    assign tx_id   = tx_head.id;
    assign tx_len  = tx_head.len;
    assign tx_data = tx_head.data;

    // Receive ring
    logic          rx_push, rx_release, rx_full, rx_empty, rx_seen;
    logic [CW-1:0] rx_cnt;
    mbx_entry_t    rx_head, rx_in;

    assign rx_ready   = rx_en_q;
    assign rx_push    = rx_valid && rx_en_q && !rx_full;
    assign rx_release = reg_wr && ctl_hit && (fld == C_RXPTR) && ptr_step && rx_en_q;
    assign rx_seen    = rx_en_q && !rx_empty;
    assign rx_in      = '{id: rx_id, len: rx_len, data: rx_data};

    can_mbx_ring #(.DEPTH(DEPTH), .W(ENTRY_W)) u_rx_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!rx_en_q),
        .push  (rx_push),
        .wdata (rx_in),
        .pop   (rx_release),
        .head  (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    // Overrun pulse for a frame dropped on a full queue
    always_ff @(posedge clk) begin
        if (!rst_n) rx_overrun <= 1'b0;
        else        rx_overrun <= rx_valid && rx_en_q && rx_full;
    end

    // Event flags: index 0 transmit, index 1 receive
    logic [1:0] irq_flags;

    can_mbx_irq #(.NF(2)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     ({rx_push, tx_pop}),
        .wr_en   (reg_wr && ctl_hit && (fld == C_ISTAT)),
        .wr_keep ({reg_wdata[IRQ_RX_BIT], reg_wdata[IRQ_TX_BIT]}),
        .flags   (irq_flags)
    );

    assign irq = |(irq_flags & ien_q);

    // Register read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (ctl_hit) begin
            case (fld)
                C_TXCTL: begin
                    reg_rdata[0]      = tx_en_q;
                    reg_rdata[1 +: CW] = tx_en_q ? tx_cnt : '0;
                end
                C_RXCTL: begin
                    reg_rdata[0]            = rx_en_q;
                    reg_rdata[RX_EMPTY_BIT] = !rx_seen;
                end
                C_ISTAT: begin
                    reg_rdata[IRQ_TX_BIT] = irq_flags[0];
                    reg_rdata[IRQ_RX_BIT] = irq_flags[1];
                end
                C_IEN: begin
                    reg_rdata[IRQ_TX_BIT] = ien_q[0];
                    reg_rdata[IRQ_RX_BIT] = ien_q[1];
                end
                default: reg_rdata = '0;
            endcase
        end else if (tx_win) begin
            case (fld)
                F_ID:    reg_rdata = stage_q.id;
                F_LEN:   reg_rdata = {{(32-LEN_W){1'b0}}, stage_q.len};
                F_DLO:   reg_rdata = stage_q.data[31:0];
                F_DHI:   reg_rdata = stage_q.data[63:32];
                default: reg_rdata = '0;
            endcase
        end else if (rx_win && rx_seen) begin
            case (fld)
                F_ID:    reg_rdata = rx_head.id;
                F_LEN:   reg_rdata = {{(32-LEN_W){1'b0}}, rx_head.len};
                F_DLO:   reg_rdata = rx_head.data[31:0];
                F_DHI:   reg_rdata = rx_head.data[63:32];
                default: reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/can_mbx_windows_chk.sv
// Temporal checks for can_mbx_windows, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module can_mbx_windows_chk #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [31:0]   tx_id,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic          rx_full,
    input logic          rx_overrun,
    input logic          rx_push,
    input logic          rx_release,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [1:0]    irq_flags
);

    // R3: occupancy never exceeds the depth
    p_tx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(DEPTH));

    // R4: an offered entry is held until taken
    p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !reg_wr |=> tx_valid && $stable(tx_id));

    // R7: a push on a full queue is followed by an overrun pulse
    p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && rx_full |=> rx_overrun);

    // R7: no overrun pulse without a push attempt on a full queue
    p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> $past(rx_valid && rx_full));

    // R8: a release without a push lowers occupancy by one
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_release && !rx_push && rx_cnt != '0 |=> rx_cnt == $past(rx_cnt) - 1'b1);

    // R9: the transmit flag only rises after a handshake
    p_txflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flags[0]) |-> $past(tx_valid && tx_ready));

endmodule

bind can_mbx_windows can_mbx_windows_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_id      (tx_id),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_full    (rx_full),
    .rx_overrun (rx_overrun),
    .rx_push    (rx_push),
    .rx_release (rx_release),
    .tx_cnt     (tx_cnt),
    .rx_cnt     (rx_cnt),
    .irq_flags  (irq_flags)
);

// File: tb/can_mbx_windows_bench.sv
`timescale 1ns/1ps
// Bench: behavioural queue model compared with the design every clock.
module can_mbx_windows_bench;

    typedef struct {
        bit [31:0] id;
        bit [3:0]  len;
        bit [63:0] data;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_valid, tx_ready = 1'b0;
    logic [31:0] tx_id;
    logic [3:0]  tx_len;
    logic [63:0] tx_data;
    logic        rx_valid = 1'b0, rx_ready;
    logic [31:0] rx_id = '0;
    logic [3:0]  rx_len = '0;
    logic [63:0] rx_data = '0;
    logic        rx_overrun, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    can_mbx_windows u_can_mbx_windows (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_id(tx_id),
        .tx_len(tx_len), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_id(rx_id),
        .rx_len(rx_len), .rx_data(rx_data),
        .rx_overrun(rx_overrun), .irq(irq)
    );

    // Reference model state
    ent_t     txq[$];
    ent_t     rxq[$];
    bit       m_tx_en, m_rx_en, m_ovr;
    bit [1:0] m_flags, m_ien;
    ent_t     st;

    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_tx_en = 0; m_rx_en = 0; m_ovr = 0;
            m_flags = 0; m_ien = 0;
            st = '{id: 0, len: 0, data: 0};
        end else begin
            automatic bit   ctl  = reg_addr[9];
            automatic int   idx  = int'(reg_addr[8:3]);
            automatic int   f    = int'(reg_addr[2:0]);
            automatic bit   ff   = (reg_wdata[7:0] == 8'hFF);
            automatic bit   pop  = m_tx_en && txq.size() > 0 && tx_ready;
            automatic bit   com  = reg_wr && ctl && f == 2 && ff && m_tx_en && txq.size() < 4;
            automatic bit   push = rx_valid && m_rx_en && rxq.size() < 4;
            automatic bit   drop = rx_valid && m_rx_en && rxq.size() == 4;
            automatic bit   rel  = reg_wr && ctl && f == 3 && ff && m_rx_en && rxq.size() > 0;
            automatic ent_t e    = st;
            automatic ent_t r    = '{id: rx_id, len: rx_len, data: rx_data};
            if (pop)  void'(txq.pop_front());
            if (com)  txq.push_back(e);
            if (rel)  void'(rxq.pop_front());
            if (push) rxq.push_back(r);
            m_ovr = drop;
            if (reg_wr && ctl && f == 4) m_flags = m_flags & {reg_wdata[4], reg_wdata[3]};
            m_flags = m_flags | {push, pop};
            if (reg_wr && ctl && f == 5) m_ien = {reg_wdata[4], reg_wdata[3]};
            if (reg_wr && !ctl && idx == 56) begin
                case (f)
                    0: st.id = reg_wdata;
                    1: st.len = reg_wdata[3:0];
                    2: st.data[31:0] = reg_wdata;
                    3: st.data[63:32] = reg_wdata;
                    default: ;
                endcase
            end
            if (reg_wr && ctl && f == 0) begin
                m_tx_en = reg_wdata[0];
                if (!m_tx_en) txq.delete();
            end
            if (reg_wr && ctl && f == 1) begin
                m_rx_en = reg_wdata[0];
                if (!m_rx_en) rxq.delete();
            end
        end
    end

    function automatic logic [31:0] exp_rd(logic [9:0] a);
        logic [31:0] r = '0;
        if (a[9]) begin
            case (a[2:0])
                3'd0: begin r[0] = m_tx_en; r[3:1] = m_tx_en ? 3'(txq.size()) : 3'd0; end
                3'd1: begin r[0] = m_rx_en; r[7] = !(m_rx_en && rxq.size() > 0); end
                3'd4: begin r[3] = m_flags[0]; r[4] = m_flags[1]; end
                3'd5: begin r[3] = m_ien[0]; r[4] = m_ien[1]; end
                default: r = '0;
            endcase
        end else if (a[8:3] == 6'd56) begin
            case (a[2:0])
                3'd0: r = st.id;
                3'd1: r = {28'd0, st.len};
                3'd2: r = st.data[31:0];
                3'd3: r = st.data[63:32];
                default: r = '0;
            endcase
        end else if (a[8:3] == 6'd60 && m_rx_en && rxq.size() > 0) begin
            case (a[2:0])
                3'd0: r = rxq[0].id;
                3'd1: r = {28'd0, rxq[0].len};
                3'd2: r = rxq[0].data[31:0];
                3'd3: r = rxq[0].data[63:32];
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    function automatic string rd_tag(logic [9:0] a);
        if (a[9]) begin
            case (a[2:0])
                3'd0: return "R5";
                3'd1: return "R8";
                3'd4, 3'd5: return "R9";
                default: return "R2";
            endcase
        end
        if (a[8:3] == 6'd60) return "R8";
        return "R2";
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual %h expected %h", req, cur_tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        automatic bit ev = m_tx_en && txq.size() > 0;
        check("R4", "tx_valid", 64'(tx_valid), 64'(ev));
        if (ev) begin
            check("R4", "tx_id", 64'(tx_id), 64'(txq[0].id));
            check("R4", "tx_len", 64'(tx_len), 64'(txq[0].len));
            check("R4", "tx_data", tx_data, txq[0].data);
        end
        check("R6", "rx_ready", 64'(rx_ready), 64'(m_rx_en));
        check("R7", "rx_overrun", 64'(rx_overrun), 64'(m_ovr));
        check("R9", "irq", 64'(irq), 64'(|(m_flags & m_ien)));
        check(rd_tag(reg_addr), "reg_rdata", 64'(reg_rdata), 64'(exp_rd(reg_addr)));
    endtask

    // One clock: drive inputs after the falling edge, then compare
    task automatic step(bit wr, logic [9:0] a, logic [31:0] d, bit rdy, bit rv);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; tx_ready = rdy; rx_valid = rv;
        #1 compare_all();
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d); step(1, a, d, 0, 0); endtask
    task automatic rd(logic [9:0] a); step(0, a, 0, 0, 0); endtask

    function automatic logic [9:0] aw(int idx, int f); return {1'b0, 6'(idx), 3'(f)}; endfunction
    function automatic logic [9:0] ac(int f); return {1'b1, 6'd0, 3'(f)}; endfunction

    task automatic set_rx(int i);
        rx_id   = (i % 2) ? (32'h8000_0000 | 32'(i * 32'h0101)) : (32'(i + 5) << 18);
        rx_len  = 4'(i + 1);
        rx_data = {32'hA5A5_0000 + 32'(i), 32'h1234_0000 + 32'(i)};
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_tag = "R1";
        rd(ac(1)); rd(ac(0)); rd(ac(4));
        rst_n = 1'b1;
        rd(ac(1)); rd(ac(5)); rd(aw(60, 0));

        cur_tag = "R5";
        wr(ac(0), 32'h1); wr(ac(1), 32'h1); wr(ac(5), 32'h18);
        rd(ac(0)); rd(ac(1)); rd(ac(5));

        // R2/R11: window write and read-back, length keeps low 4 bits
        cur_tag = "R11";
        wr(aw(56, 0), 32'hC123_4567); wr(aw(56, 1), 32'hFFFF_FFF8);
        wr(aw(56, 2), 32'h0302_0100); wr(aw(56, 3), 32'h0706_0504);
        for (int f = 0; f < 8; f++) rd(aw(56, f));
        rd(aw(57, 0)); rd(aw(60, 0));

        // R3: non-step pointer value ignored; fifth commit ignored on full
        cur_tag = "R3";
        wr(ac(2), 32'h7F); rd(ac(0));
        for (int i = 0; i < 5; i++) begin
            wr(aw(56, 0), 32'(i + 1) << 18);
            wr(aw(56, 1), 32'(i));
            wr(ac(2), 32'hFF);
            rd(ac(0));
        end

        // R4: drain in commit order with a stall in between
        cur_tag = "R4";
        step(0, ac(0), 0, 1, 0); step(0, ac(0), 0, 0, 0);
        for (int i = 0; i < 5; i++) step(0, ac(4), 0, 1, 0);

        // R9: clear transmit flag, keep receive flag
        cur_tag = "R9";
        wr(ac(4), 32'h10); rd(ac(4)); wr(ac(4), 32'h0); rd(ac(4));

        // R6/R7: five pushes, the fifth is dropped on full
        cur_tag = "R7";
        for (int i = 0; i < 5; i++) begin set_rx(i); step(0, aw(60, 0), 0, 0, 1); end
        rd(ac(1)); rd(ac(1));

        // R8: read and release each frame, then release on empty
        cur_tag = "R8";
        wr(ac(3), 32'h12); rd(aw(60, 0));
        for (int i = 0; i < 5; i++) begin
            for (int f = 0; f < 4; f++) rd(aw(60, f));
            wr(ac(3), 32'hFF);
            rd(ac(1));
        end

        // R9: set wins over a same-cycle clear
        cur_tag = "R9";
        set_rx(7); step(1, ac(4), 32'h0, 0, 1); rd(ac(4));
        wr(ac(5), 32'h08); rd(ac(4)); wr(ac(4), 32'h0); rd(ac(4));
        wr(ac(3), 32'hFF);

        // R3/R4: commit in the same cycle as a drain
        cur_tag = "R3";
        wr(aw(56, 0), 32'h8000_00AA); wr(ac(2), 32'hFF);
        wr(aw(56, 0), 32'h4000_00BB); step(1, ac(2), 32'hFF, 1, 0);
        rd(ac(0)); step(0, ac(0), 0, 1, 0); rd(ac(0));

        // R10: disabling empties each queue
        cur_tag = "R10";
        wr(ac(2), 32'hFF); wr(ac(2), 32'hFF); rd(ac(0));
        wr(ac(0), 32'h0); rd(ac(0)); wr(ac(2), 32'hFF); rd(ac(0));
        wr(ac(0), 32'h1); rd(ac(0)); step(0, ac(0), 0, 1, 0);
        set_rx(3); step(0, ac(1), 0, 0, 1); set_rx(4); step(0, ac(1), 0, 0, 1);
        wr(ac(1), 32'h0); rd(ac(1)); rd(aw(60, 0));
        set_rx(5); step(0, ac(1), 0, 0, 1);
        wr(ac(1), 32'h1); rd(ac(1)); rd(aw(60, 0));

        // R6: stored again after re-enable
        cur_tag = "R6";
        set_rx(9); step(0, aw(60, 0), 0, 0, 1); rd(aw(60, 0)); rd(aw(60, 1));
        rd(ac(4));

        done = 1;
        summary();
        $finish;
    end

endmodule